// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block is the host side of a PS/2 serial link. It exchanges single bytes with a keyboard or mouse over two open-drain lines: a clock that the device normally generates and a data line. A bus master controls it through three byte-wide registers: a data buffer, a control register and a status register. In receive direction the block samples the bits the device sends. It checks parity and the stop bit as software has set them, and it keeps the byte for the bus. While that byte is unread, it pulls the clock line low so the device cannot send again.

In transmit direction a write to the data buffer starts a request-to-send. The block inhibits the clock, presents the start bit and then shifts out the byte on the falling edges of the device clock. It then takes the device's acknowledge. Three timers supervise the link: one for the device's first edge after a request, one for a whole transmit frame, and one for the gap between edges inside a received frame. Each line input passes through a two-flop synchroniser and a stability filter before any edge is detected. A single interrupt output summarises the pending conditions.

Top module: `ps2_port`

## Requirements
- R1: After reset the status register (offset 0x8) reads 0x10, the control register (offset 0x4) reads 0x00, the interrupt is low and neither line is pulled low.
- R2: A received frame is taken on falling device-clock edges in the order start, data bit 0 to 7, parity, stop. A clean frame sets status bit 0 and stores the byte, which a read of offset 0x0 returns. That read clears status bit 0.
- R3: While status bit 0 is set, in receive direction with the block enabled, the clock line is pulled low. It is released after the data buffer is read.
- R4: Control bits [3:2] select the parity check: 0 odd, 1 even, 2 and 3 no check. A mismatch sets status bit 2 and the byte is not stored (bit 0 stays clear).
- R5: A start bit of 1, or a stop bit that fails the check set by control bits [5:4], sets status bit 3 (framing error). The codes are 0 = stop must be 1, 1 = stop must be 0, 2 and 3 = no check.
- R6: Writing 1 clears status bits 1, 2, 3, 5 and 7. Writes have no effect on bits 0, 4 and 6.
- R7: The interrupt output is high when status bit 0 or any of bits 1, 2, 3, 5, 7 is set, and low otherwise.
- R8: With control bit 0 = 1 (transmit) and bit 1 = 1 (enable), a write to offset 0x0 starts a transmit. The clock is pulled low for at least 100 us, then data is pulled low (start bit) and the clock is released. On the following falling edges the block presents data bits 0 to 7, then a parity bit, then a stop bit of 1. The parity bit is even when control bits [3:2] = 1 and odd otherwise. Status bit 4 is low from the write until the end of the frame.
- R9: On the eleventh falling edge of a transmit the data line must be low (acknowledge). If it is high, status bit 3 is set.
- R10: If no falling clock edge arrives within 25 ms of the clock being released after a transmit request, status bit 7 is set, both lines are released and status bit 4 returns high.
- R11: If a transmit frame is not finished within 2 ms of its first falling edge, status bit 5 is set and the transmitter returns to idle.
- R12: Status bit 6 is high while a received frame is in progress. If 2 ms pass without a falling edge inside such a frame, status bit 1 is set and bit 6 clears.
- R13: A low pulse on the clock line shorter than the filter length (default 4 cycles) produces no edge and does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Level interrupt |
| ps2_clk_in | input | 1 | Sensed level of the clock line |
| ps2_clk_pull | output | 1 | High pulls the clock line low |
| ps2_dat_in | input | 1 | Sensed level of the data line |
| ps2_dat_pull | output | 1 | High pulls the data line low |

## Verification
A wrong bit counter or a swapped shift direction shows at the data buffer one frame later, as a rotated or shifted byte or as a false parity or framing flag. A stuck state shows as status bit 4 or 6 staying at the wrong level on the next status read. A timer that counts wrongly shows as a timeout flag that is early, late or missing by the size of the window. The check is made a few hundred cycles after the window ends. Hold-off and line-drive faults are visible on the pull outputs in the cycle after the state changes.

// File: rtl/ps2_pkg.sv
package ps2_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_INH, ST_REQ, ST_TX} ps2_state_e;

  // Register offsets
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_CTRL = 4;
  localparam int unsigned OFS_STAT = 8;

  // Control register layout, MSB first
  typedef struct packed {
    logic [1:0] stop_mode;
    logic [1:0] par_mode;
    logic       enable;
    logic       dir_tx;
  } ps2_ctrl_t;

  // Status bits that are cleared by writing one
  localparam logic [7:0] W1C_MASK = 8'hAE;
endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int unsigned STABLE = 4,
  parameter logic        INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(STABLE + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= INIT;
      s2   <= INIT;
      dout <= INIT;
      cnt  <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(STABLE - 1)) begin
        dout <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ps2_engine.sv
module ps2_engine
  import ps2_pkg::*;
#(
  parameter int unsigned INH_CYC   = 100,
  parameter int unsigned START_CYC = 25000,
  parameter int unsigned FRAME_CYC = 2000,
  parameter int unsigned GAP_CYC   = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       dir_tx,
  input  logic [1:0] par_mode,
  input  logic [1:0] stop_mode,
  input  logic       hold,
  input  logic       tx_go,
  input  logic [7:0] tx_byte,
  input  logic       clk_fall,
  input  logic       dat_lvl,
  output logic       clk_pull,
  output logic       dat_pull,
  output logic       rx_done,
  output logic [7:0] rx_byte,
  output logic       ev_pe,
  output logic       ev_fe,
  output logic       ev_rxto,
  output logic       ev_txto,
  output logic       ev_txst,
  output logic       tx_idle,
  output logic       rx_busy
);
  localparam int unsigned TA   = (INH_CYC > START_CYC) ? INH_CYC : START_CYC;
  localparam int unsigned TB   = (FRAME_CYC > GAP_CYC) ? FRAME_CYC : GAP_CYC;
  localparam int unsigned TMAX = (TA > TB) ? TA : TB;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  ps2_state_e    st;
  logic [TW-1:0] tmr;
  logic [3:0]    bitn;
  logic [9:0]    sr;
  logic [9:0]    txs;
  logic [10:0]   full;
  logic          odd_ok, par_bad, stop_bad, frame_bad, tx_par;

  // full[0] start, full[8:1] data, full[9] parity, full[10] stop
  assign full      = {dat_lvl, sr};
  assign odd_ok    = ^full[9:1];
  assign par_bad   = (par_mode == 2'd0 && !odd_ok) || (par_mode == 2'd1 && odd_ok);
  assign stop_bad  = (stop_mode == 2'd0 && !full[10]) || (stop_mode == 2'd1 && full[10]);
  assign frame_bad = full[0] || stop_bad;
  assign tx_par    = (par_mode == 2'd1) ? ^tx_byte : ~^tx_byte;

  assign clk_pull = enable && ((st == ST_INH) || (st == ST_IDLE && !dir_tx && hold));
  assign tx_idle  = !(st == ST_INH || st == ST_REQ || st == ST_TX);
  assign rx_busy  = (st == ST_RX);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      tmr      <= '0;
      bitn     <= '0;
      sr       <= '0;
      txs      <= '0;
      dat_pull <= 1'b0;
      rx_done  <= 1'b0;
      rx_byte  <= '0;
      ev_pe    <= 1'b0;
      ev_fe    <= 1'b0;
      ev_rxto  <= 1'b0;
      ev_txto  <= 1'b0;
      ev_txst  <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      ev_pe   <= 1'b0;
      ev_fe   <= 1'b0;
      ev_rxto <= 1'b0;
      ev_txto <= 1'b0;
      ev_txst <= 1'b0;
      if (!enable) begin
        st       <= ST_IDLE;
        dat_pull <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: begin
            tmr  <= '0;
            bitn <= '0;
            if (dir_tx) begin
              if (tx_go) begin
                txs <= {1'b1, tx_par, tx_byte};
                st  <= ST_INH;
              end
            end else if (clk_fall && !hold) begin
              sr   <= {dat_lvl, sr[9:1]};
              bitn <= 4'd1;
              st   <= ST_RX;
            end
          end
          ST_RX: begin
            if (clk_fall) begin
              tmr <= '0;
              sr  <= {dat_lvl, sr[9:1]};
              if (bitn == 4'd10) begin
                st      <= ST_IDLE;
                ev_pe   <= par_bad;
                ev_fe   <= frame_bad;
                rx_done <= !par_bad && !frame_bad;
                rx_byte <= full[8:1];
              end else begin
                bitn <= bitn + 4'd1;
              end
            end else if (tmr == TW'(GAP_CYC - 1)) begin
              ev_rxto <= 1'b1;
              st      <= ST_IDLE;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_INH: begin
            if (tmr == TW'(INH_CYC - 1)) begin
              tmr      <= '0;
              dat_pull <= 1'b1;
              st       <= ST_REQ;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_REQ: begin
            if (clk_fall) begin
              dat_pull <= ~txs[0];
              txs      <= {1'b1, txs[9:1]};
              bitn     <= 4'd1;
              tmr      <= '0;
              st       <= ST_TX;
            end else if (tmr == TW'(START_CYC - 1)) begin
              ev_txst  <= 1'b1;
              dat_pull <= 1'b0;
              st       <= ST_IDLE;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_TX: begin
            if (clk_fall) begin
              if (bitn == 4'd10) begin
                ev_fe    <= dat_lvl;
                dat_pull <= 1'b0;
                st       <= ST_IDLE;
              end else begin
                dat_pull <= ~txs[0];
                txs      <= {1'b1, txs[9:1]};
                bitn     <= bitn + 4'd1;
              end
            end else if (tmr == TW'(FRAME_CYC - 1)) begin
              ev_txto  <= 1'b1;
              dat_pull <= 1'b0;
              st       <= ST_IDLE;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ps2_port.sv
module ps2_port
  import ps2_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned AW     = 4,
  parameter int unsigned FILT   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq,
  input  logic          ps2_clk_in,
  output logic          ps2_clk_pull,
  input  logic          ps2_dat_in,
  output logic          ps2_dat_pull
);
  localparam int unsigned INH_CYC   = CLK_HZ / 10_000;  // 100 us
  localparam int unsigned START_CYC = CLK_HZ / 40;      // 25 ms
  localparam int unsigned FRAME_CYC = CLK_HZ / 500;     // 2 ms
  localparam int unsigned GAP_CYC   = CLK_HZ / 500;     // 2 ms
  localparam int unsigned NLINES    = 2;

  ps2_ctrl_t         ctrl;
  logic              rdy_q, rxto_q, pe_q, fe_q, txto_q, txst_q;
  logic [7:0]        rx_buf, status, clr;
  logic [NLINES-1:0] raw, filt;
  logic              clk_prev, clk_fall;
  logic              sel_data, sel_ctrl, sel_stat, tx_go;
  logic              eng_rx_done, eng_ev_pe, eng_ev_fe, eng_ev_rxto, eng_ev_txto, eng_ev_txst;
  logic              eng_tx_idle, eng_rx_busy;
  logic [7:0]        eng_rx_byte;

  // index 0: clock line, index 1: data line
  assign raw = {ps2_dat_in, ps2_clk_in};

  for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
    ps2_line_filter #(.STABLE(FILT), .INIT(1'b1)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw[gi]),
      .dout(filt[gi])
    );
  end

  assign clk_fall = clk_prev && !filt[0];
  assign sel_data = (bus_addr == AW'(OFS_DATA));
  assign sel_ctrl = (bus_addr == AW'(OFS_CTRL));
  assign sel_stat = (bus_addr == AW'(OFS_STAT));
  assign tx_go    = bus_wr && sel_data && ctrl.enable && ctrl.dir_tx && eng_tx_idle;
  assign clr      = (bus_wr && sel_stat) ? (bus_wdata & W1C_MASK) : 8'h00;
  assign status   = {txst_q, eng_rx_busy, txto_q, eng_tx_idle, fe_q, pe_q, rxto_q, rdy_q};

  ps2_engine #(
    .INH_CYC  (INH_CYC),
    .START_CYC(START_CYC),
    .FRAME_CYC(FRAME_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_eng (
    .clk      (clk),
    .rst      (rst),
    .enable   (ctrl.enable),
    .dir_tx   (ctrl.dir_tx),
    .par_mode (ctrl.par_mode),
    .stop_mode(ctrl.stop_mode),
    .hold     (rdy_q),
    .tx_go    (tx_go),
    .tx_byte  (bus_wdata),
    .clk_fall (clk_fall),
    .dat_lvl  (filt[1]),
    .clk_pull (ps2_clk_pull),
    .dat_pull (ps2_dat_pull),
    .rx_done  (eng_rx_done),
    .rx_byte  (eng_rx_byte),
    .ev_pe    (eng_ev_pe),
    .ev_fe    (eng_ev_fe),
    .ev_rxto  (eng_ev_rxto),
    .ev_txto  (eng_ev_txto),
    .ev_txst  (eng_ev_txst),
    .tx_idle  (eng_tx_idle),
    .rx_busy  (eng_rx_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      rdy_q     <= 1'b0;
      rxto_q    <= 1'b0;
      pe_q      <= 1'b0;
      fe_q      <= 1'b0;
      txto_q    <= 1'b0;
      txst_q    <= 1'b0;
      rx_buf    <= '0;
      bus_rdata <= '0;
      irq       <= 1'b0;
      clk_prev  <= 1'b1;
    end else begin
      clk_prev <= filt[0];
      if (bus_wr && sel_ctrl) ctrl <= ps2_ctrl_t'(bus_wdata[5:0]);
      if (eng_rx_done) rx_buf <= eng_rx_byte;
      rdy_q  <= eng_rx_done || (rdy_q && !(bus_rd && sel_data));
      rxto_q <= eng_ev_rxto || (rxto_q && !clr[1]);
      pe_q   <= eng_ev_pe   || (pe_q   && !clr[2]);
      fe_q   <= eng_ev_fe   || (fe_q   && !clr[3]);
      txto_q <= eng_ev_txto || (txto_q && !clr[5]);
      txst_q <= eng_ev_txst || (txst_q && !clr[7]);
      if (bus_rd) begin
        if (sel_data)      bus_rdata <= rx_buf;
        else if (sel_ctrl) bus_rdata <= {2'b00, ctrl};
        else if (sel_stat) bus_rdata <= status;
        else               bus_rdata <= 8'h00;
      end
      irq <= rdy_q || rxto_q || pe_q || fe_q || txto_q || txst_q;
    end
  end
endmodule

// File: rtl/ps2_port_chk.sv
module ps2_port_chk #(
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          clr_pe_bit,
  input logic          clk_pull,
  input logic          dat_pull,
  input logic          rdy_q,
  input logic          pe_q,
  input logic          ev_pe,
  input logic          ev_txst,
  input logic          ev_rxto,
  input logic          ev_txto,
  input logic          rx_done,
  input logic          tx_idle,
  input logic          rx_busy
);
  // R8
  oe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    dat_pull |-> !clk_pull);

  // R3
  hold_clock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> clk_pull);

  // R6
  w1c_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(8) && clr_pe_bit && !ev_pe) |=> !pe_q);

  // R10
  start_timeout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ev_txst |-> (tx_idle && !dat_pull));

  // R12
  rx_timeout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ev_rxto |-> !rx_busy);

  // R2
  frame_end_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_done, ev_rxto, ev_txst, ev_txto}));
endmodule

bind ps2_port ps2_port_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .clr_pe_bit(bus_wdata[2]),
  .clk_pull  (ps2_clk_pull),
  .dat_pull  (ps2_dat_pull),
  .rdy_q     (rdy_q),
  .pe_q      (pe_q),
  .ev_pe     (eng_ev_pe),
  .ev_txst   (eng_ev_txst),
  .ev_rxto   (eng_ev_rxto),
  .ev_txto   (eng_ev_txto),
  .rx_done   (eng_rx_done),
  .tx_idle   (eng_tx_idle),
  .rx_busy   (eng_rx_busy)
);

// File: tb/test_ps2_port.sv
`timescale 1ns/1ps
module test_ps2_port;
  // Timers are scaled by telling the block its clock is 1 MHz:
  // 100 us = 100 cycles, 2 ms = 2000 cycles, 25 ms = 25000 cycles.
  localparam int unsigned CLK_HZ = 1_000_000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr = 1'b0, rd = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, clk_pull, dat_pull;
  logic       dev_clk_low = 1'b0, dev_dat_low = 1'b0;
  logic       line_clk, line_dat;
  int         nchk = 0, nerr = 0;

  assign line_clk = ~(clk_pull | dev_clk_low);
  assign line_dat = ~(dat_pull | dev_dat_low);

  always #2 clk = ~clk;

  ps2_port #(.CLK_HZ(CLK_HZ), .AW(4), .FILT(4)) i_ps2_port (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (wr),
    .bus_rd      (rd),
    .bus_addr    (addr),
    .bus_wdata   (wdata),
    .bus_rdata   (rdata),
    .irq         (irq),
    .ps2_clk_in  (line_clk),
    .ps2_clk_pull(clk_pull),
    .ps2_dat_in  (line_dat),
    .ps2_dat_pull(dat_pull)
  );

  // {byte, par_mode, stop_mode, start, flip, stop_bit, exp_ready, exp_pe, exp_fe}
  // flip=0 sends the odd-parity bit, flip=1 the even-parity bit
  localparam int NVEC = 13;
  localparam logic [17:0] VEC [NVEC] = '{
    {8'hA5, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 3'b100},
    {8'h3C, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 3'b010},
    {8'h3C, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 3'b100},
    {8'h81, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 3'b010},
    {8'h7E, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 3'b100},
    {8'h00, 2'd3, 2'd0, 1'b0, 1'b1, 1'b1, 3'b100},
    {8'h55, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'b001},
    {8'h55, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 3'b100},
    {8'h55, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 3'b001},
    {8'h12, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 3'b100},
    {8'h12, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 3'b100},
    {8'hF0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 3'b001},
    {8'h99, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 3'b011}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  // device sends bits[0] first; n bits
  task automatic dev_send(input logic [10:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      dev_dat_low = ~bits[i];
      tick(20);
      dev_clk_low = 1'b1;
      tick(40);
      dev_clk_low = 1'b0;
      tick(20);
    end
    dev_dat_low = 1'b0;
  endtask

  // device clocks a host transmit; rec holds the line value in each low phase
  task automatic dev_recv(input logic give_ack, input int pulses, output logic [9:0] rec);
    int guard;
    guard = 0;
    rec = '0;
    while (!dat_pull && guard < 1000) begin
      tick(1);
      guard++;
    end
    tick(30);
    for (int k = 1; k <= pulses; k++) begin
      if (k == 11 && give_ack) dev_dat_low = 1'b1;
      dev_clk_low = 1'b1;
      tick(35);
      if (k <= 10) rec[k-1] = line_dat;
      tick(5);
      dev_clk_low = 1'b0;
      tick(40);
    end
    dev_dat_low = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0]  s, d, byt;
    logic [17:0] v;
    logic [10:0] frm;
    logic [9:0]  rec;
    logic        pbit;
    int          cnt;

    tick(5);
    rst = 1'b0;
    tick(2);

    // R1 reset state
    check("R1 lines", {14'd0, clk_pull, dat_pull}, 16'h0);
    check("R1 irq", {15'd0, irq}, 16'h0);
    bus_read(4'h8, s);
    check("R1 status", {8'd0, s}, 16'h0010);
    bus_read(4'h4, s);
    check("R1 ctrl", {8'd0, s}, 16'h0000);

    // R2 R4 R5 R7 R3: receive vectors
    for (int i = 0; i < NVEC; i++) begin
      v    = VEC[i];
      byt  = v[17:10];
      pbit = (~^byt) ^ v[4];
      frm  = {v[3], pbit, byt, v[5]};
      bus_write(4'h4, {2'b00, v[7:6], v[9:8], 1'b1, 1'b0});
      dev_send(frm, 11);
      tick(30);
      bus_read(4'h8, s);
      check("R2/R4/R5 flags", {13'd0, s[0], s[2], s[3]}, {13'd0, v[2:0]});
      check("R7 irq level", {15'd0, irq}, {15'd0, |v[2:0]});
      if (v[2]) begin
        check("R3 clock held", {15'd0, clk_pull}, 16'h1);
        bus_read(4'h0, d);
        check("R2 data", {8'd0, d}, {8'd0, byt});
        tick(2);
        check("R3 clock freed", {15'd0, clk_pull}, 16'h0);
        bus_read(4'h8, s);
        check("R2 ready cleared", {15'd0, s[0]}, 16'h0);
      end
      bus_write(4'h8, 8'hFF);
      tick(3);
    end

    // R6 write-one-to-clear and read-only bits
    bus_write(4'h4, 8'h02);
    dev_send({1'b1, ~(~^8'h3C), 8'h3C, 1'b0}, 11);
    tick(30);
    bus_read(4'h8, s);
    check("R6 pe set", {8'd0, s}, 16'h0014);
    check("R7 irq on error", {15'd0, irq}, 16'h1);
    bus_write(4'h8, 8'h51);
    bus_read(4'h8, s);
    check("R6 ro write no effect", {8'd0, s}, 16'h0014);
    bus_write(4'h8, 8'h04);
    tick(3);
    bus_read(4'h8, s);
    check("R6 pe cleared", {8'd0, s}, 16'h0010);
    check("R7 irq low", {15'd0, irq}, 16'h0);
    dev_send({1'b1, ~^8'h3C, 8'h3C, 1'b0}, 11);
    tick(30);
    bus_write(4'h8, 8'hFF);
    bus_read(4'h8, s);
    check("R6 ready survives w1", {8'd0, s}, 16'h0011);
    bus_read(4'h0, d);
    check("R2 data after w1", {8'd0, d}, 16'h003C);

    // R13 glitch on clock is filtered
    tick(5);
    dev_clk_low = 1'b1;
    tick(2);
    dev_clk_low = 1'b0;
    tick(20);
    bus_read(4'h8, s);
    check("R13 glitch ignored", {8'd0, s}, 16'h0010);

    // R12 receive timeout
    dev_send(11'b111_1010_1010, 3);
    bus_read(4'h8, s);
    check("R12 busy mid frame", {8'd0, s}, 16'h0050);
    tick(2100);
    bus_read(4'h8, s);
    check("R12 rx timeout", {8'd0, s}, 16'h0012);
    bus_write(4'h8, 8'h02);

    // R8 transmit with acknowledge
    bus_write(4'h4, 8'h03);
    bus_write(4'h0, 8'hA6);
    cnt = 0;
    while (clk_pull && cnt < 1000) begin
      cnt++;
      tick(1);
    end
    check("R8 inhibit >= 100us", {15'd0, cnt >= 100}, 16'h1);
    check("R8 start bit", {14'd0, dat_pull, clk_pull}, 16'h2);
    bus_read(4'h8, s);
    check("R8 tx not idle", {15'd0, s[4]}, 16'h0);
    dev_recv(1'b1, 11, rec);
    tick(20);
    check("R8 tx data", {8'd0, rec[7:0]}, 16'h00A6);
    check("R8 tx parity+stop", {14'd0, rec[9:8]}, {14'd0, 1'b1, ~^8'hA6});
    bus_read(4'h8, s);
    check("R9 ack ok", {8'd0, s}, 16'h0010);

    // R9 missing acknowledge
    bus_write(4'h0, 8'h5A);
    dev_recv(1'b0, 11, rec);
    tick(20);
    check("R8 tx data 2", {8'd0, rec[7:0]}, 16'h005A);
    bus_read(4'h8, s);
    check("R9 no ack", {8'd0, s}, 16'h0018);
    bus_write(4'h8, 8'h08);

    // R10 start timeout
    bus_write(4'h0, 8'h11);
    tick(25300);
    bus_read(4'h8, s);
    check("R10 start timeout", {8'd0, s}, 16'h0090);
    check("R10 lines free", {14'd0, dat_pull, clk_pull}, 16'h0);
    bus_write(4'h8, 8'h80);

    // R11 frame timeout
    bus_write(4'h0, 8'h22);
    dev_recv(1'b0, 1, rec);
    tick(2200);
    bus_read(4'h8, s);
    check("R11 frame timeout", {8'd0, s}, 16'h0030);
    check("R11 data freed", {15'd0, dat_pull}, 16'h0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule